// File: doc/BRIEF.md
# Four-Strike Watchdog with Paired Prescale Timer

This block is a memory-mapped watchdog that guards a system against a stalled CPU. A prescale timer divides an incoming tick enable (nominally 1 MHz) into heartbeat events. A watchdog countdown uses those events to count down from a programmed period. Each time the countdown runs out it reloads itself and bumps a two-bit strike counter. A system reset pulse is raised only on the fourth strike, so software has three full periods of slack before the chip is reset. An optional interrupt flags the first strike, which gives software a chance to recover before the reset.

Software reaches the block over a simple 32-bit register bus with a write strobe, a read strobe, an address and data. The registers are configuration (0x00), status (0x04), command (0x08), unlock (0x0C) and timer (0x10). The usual sequence is: program the timer reload and enables, program the period and the reset and interrupt enables, then write the start command. The same start command later serves as the keep-alive ping. A disable command is honoured only after the 16-bit key 0xC45A has been written to the unlock register.

Top module: `wdog_quad_expire`

## Requirements
- R1: After reset, every register reads zero, the watchdog is stopped, and `irq_o` and `sys_rst_o` are low.
- R2: Timer register layout is bit 31 enable, bit 30 periodic, and the reload value in the low TIMER_W bits (TIMER_W is at most 30). Writing the register loads the count. When enabled, the timer fires once every `reload` ticks (a reload of 0 behaves like 1). In one-shot mode (bit 30 clear) the firing clears bit 31.
- R3: Configuration reads back as written: bits 3:0 hold the timer id, bits 11:4 the period, bit 12 the interrupt enable and bit 15 the reset enable. All other bits read zero.
- R4: A command write with bit 0 set starts the watchdog, or restarts it if already running. It loads the countdown (status bits 11:4) with the period, sets status bit 0 (running), and reloads the timer count. While the watchdog is running, each timer firing decrements the countdown.
- R5: A timer firing that arrives while the countdown is 1 or 0 is an expiration. It reloads the countdown with the period and increments the expiration count in status bits 13:12.
- R6: When the reset enable is set, the expiration that arrives while the expiration count is 3 (the fourth expiration) raises `sys_rst_o` for exactly one cycle. It also clears the running bit and the expiration count.
- R7: A start command clears the expiration count and `irq_o`. If it coincides with an expiration, the command takes precedence.
- R8: A command write with bit 1 set and bit 0 clear has no effect unless the unlock key is armed.
- R9: Writing 0xC45A to the low 16 bits of the unlock register arms the key, and any other value disarms it. The next command write consumes the key whatever its content. A disable while armed clears the running bit.
- R10: With the interrupt enable set, every expiration sets `irq_o`, and it stays high until a start command.
- R11: With the reset enable clear, the fourth expiration wraps the expiration count to 0, gives no reset pulse, and the watchdog keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase tick enable |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; read data is zero when low |
| bus_addr | input | 5 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_o | output | 1 | Sticky early-warning interrupt |
| sys_rst_o | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with TIMER_W set to 8 and programs reloads of 1 to 3 ticks and periods of 1 to 4. With those values the whole four-strike sequence, including the reset pulse, the count wrap and the one-shot timer stop, completes in a few dozen cycles. This lets thousands of random cycles cover collisions between commands and expirations, including a restart that lands in the same cycle as a fourth expiration.

// File: rtl/wdog_quad_expire.sv
module wdog_quad_expire #(
  parameter int TIMER_W = 29
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_o,
  output logic        sys_rst_o
);
  localparam logic [4:0]  A_CFG = 5'h00;
  localparam logic [4:0]  A_STS = 5'h04;
  localparam logic [4:0]  A_CMD = 5'h08;
  localparam logic [4:0]  A_KEY = 5'h0C;
  localparam logic [4:0]  A_TMR = 5'h10;
  localparam logic [15:0] KEY   = 16'hC45A;
  localparam int          PAD_W = 30 - TIMER_W;

  logic               t_en, t_per;
  logic [TIMER_W-1:0] t_rel, t_cnt;
  logic               w_run, unl, ien, ren;
  logic [7:0]         w_cnt, period;
  logic [1:0]         w_exp;
  logic [3:0]         tid;

  wire wr_cfg    = bus_wr && bus_addr == A_CFG;
  wire wr_cmd    = bus_wr && bus_addr == A_CMD;
  wire wr_key    = bus_wr && bus_addr == A_KEY;
  wire wr_tmr    = bus_wr && bus_addr == A_TMR;
  wire cmd_start = wr_cmd && bus_wdata[0];
  wire t_fire    = t_en && tick_i && (t_cnt <= TIMER_W'(1));
  wire w_expire  = w_run && t_fire && (w_cnt <= 8'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_en <= 1'b0; t_per <= 1'b0; t_rel <= '0; t_cnt <= '0;
    end else begin
      if (t_fire) begin
        t_cnt <= t_rel;
        if (!t_per) t_en <= 1'b0;
      end else if (t_en && tick_i) begin
        t_cnt <= t_cnt - TIMER_W'(1);
      end
      if (wr_tmr) begin
        t_en  <= bus_wdata[31];
        t_per <= bus_wdata[30];
        t_rel <= bus_wdata[TIMER_W-1:0];
        t_cnt <= bus_wdata[TIMER_W-1:0];
      end else if (cmd_start) begin
        t_cnt <= t_rel;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_run <= 1'b0; unl <= 1'b0; ien <= 1'b0; ren <= 1'b0;
      w_cnt <= '0; period <= '0; w_exp <= '0; tid <= '0;
      irq_o <= 1'b0; sys_rst_o <= 1'b0;
    end else begin
      sys_rst_o <= 1'b0;
      if (w_run && t_fire) begin
        if (w_expire) begin
          w_cnt <= period;
          if (ien) irq_o <= 1'b1;
          if (w_exp == 2'd3) begin
            w_exp <= 2'd0;
            if (ren) begin
              sys_rst_o <= 1'b1;
              w_run     <= 1'b0;
            end
          end else begin
            w_exp <= w_exp + 2'd1;
          end
        end else begin
          w_cnt <= w_cnt - 8'd1;
        end
      end
      if (wr_cfg) begin
        tid    <= bus_wdata[3:0];
        period <= bus_wdata[11:4];
        ien    <= bus_wdata[12];
        ren    <= bus_wdata[15];
      end
      if (wr_cmd) begin
        unl <= 1'b0;
        if (bus_wdata[0]) begin
          w_run     <= 1'b1;
          w_cnt     <= period;
          w_exp     <= 2'd0;
          irq_o     <= 1'b0;
          sys_rst_o <= 1'b0;
        end else if (bus_wdata[1] && unl) begin
          w_run <= 1'b0;
        end
      end
      if (wr_key) unl <= (bus_wdata[15:0] == KEY);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_CFG:   bus_rdata = {16'd0, ren, 2'd0, ien, period, tid};
        A_STS:   bus_rdata = {18'd0, w_exp, w_cnt, 3'd0, w_run};
        A_TMR:   bus_rdata = {t_en, t_per, {PAD_W{1'b0}}, t_rel};
        default: bus_rdata = '0;
      endcase
    end
  end

  p_rst_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |=> !sys_rst_o);
  p_rst_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |-> (!w_run && w_exp == 2'd0));
  p_locked_disable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !bus_wdata[0] && !unl && w_run && !t_fire) |=> w_run);
  p_exp_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(w_exp) |-> (w_exp == $past(w_exp) + 2'd1 || w_exp == 2'd0));
  p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(cmd_start));
  p_key_consumed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !wr_key) |=> !unl);
endmodule

// File: tb/wdog_quad_expire_tb_top.sv
`timescale 1ns/1ps
module wdog_quad_expire_tb_top;
  localparam int TW = 8;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq, srst;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  wdog_quad_expire #(.TIMER_W(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq), .sys_rst_o(srst));

  // reference state
  logic m_ten, m_tper, m_run, m_unl, m_ien, m_ren, m_irq, m_rst;
  logic [TW-1:0] m_rel, m_tcnt;
  logic [7:0] m_cnt, m_per;
  logic [1:0] m_exp;
  logic [3:0] m_id;

  task automatic mclear();
    m_ten = 0; m_tper = 0; m_run = 0; m_unl = 0; m_ien = 0; m_ren = 0;
    m_irq = 0; m_rst = 0; m_rel = 0; m_tcnt = 0; m_cnt = 0; m_per = 0;
    m_exp = 0; m_id = 0;
  endtask

  function automatic logic [31:0] mread(input logic [4:0] a);
    case (a)
      5'h00: return {16'd0, m_ren, 2'd0, m_ien, m_per, m_id};
      5'h04: return {18'd0, m_exp, m_cnt, 3'd0, m_run};
      5'h10: return {m_ten, m_tper, 22'd0, m_rel};
      default: return 32'd0;
    endcase
  endfunction

  task automatic mstep(input logic w, input logic [4:0] a, input logic [31:0] d,
                       input logic t);
    logic fire;
    fire = m_ten && t && (m_tcnt <= 1);
    m_rst = 0;
    if (fire) begin m_tcnt = m_rel; if (!m_tper) m_ten = 0; end
    else if (m_ten && t) m_tcnt = m_tcnt - 1;
    if (m_run && fire) begin
      if (m_cnt <= 1) begin
        m_cnt = m_per;
        if (m_ien) m_irq = 1;
        if (m_exp == 3) begin
          m_exp = 0;
          if (m_ren) begin m_rst = 1; m_run = 0; end
        end else m_exp = m_exp + 1;
      end else m_cnt = m_cnt - 1;
    end
    if (w) begin
      case (a)
        5'h00: begin m_id = d[3:0]; m_per = d[11:4]; m_ien = d[12]; m_ren = d[15]; end
        5'h08: begin
          if (d[0]) begin
            m_run = 1; m_cnt = m_per; m_exp = 0; m_irq = 0; m_rst = 0; m_tcnt = m_rel;
          end else if (d[1] && m_unl) m_run = 0;
          m_unl = 0;
        end
        5'h0C: m_unl = (d[15:0] == 16'hC45A);
        5'h10: begin m_ten = d[31]; m_tper = d[30]; m_rel = d[TW-1:0]; m_tcnt = d[TW-1:0]; end
        default: ;
      endcase
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle: inputs driven at negedge, outputs checked at next negedge
  task automatic cyc(input logic w, input logic [4:0] a, input logic [31:0] d,
                     input logic t, input string req);
    bus_wr = w; bus_rd = !w; bus_addr = a; bus_wdata = d; tick = t;
    #0.1;
    if (!w) chk(req, bus_rdata, mread(a));
    mstep(w, a, d, t);
    @(negedge clk);
    chk("R10 irq", {31'd0, irq}, {31'd0, m_irq});
    chk("R6 sys_rst", {31'd0, srst}, {31'd0, m_rst});
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic t = 0);
    cyc(1, a, d, t, "wr");
  endtask

  task automatic rd_exp(input logic [4:0] a, input logic [31:0] lit, input string req);
    bus_wr = 0; bus_rd = 1; bus_addr = a; tick = 0;
    #0.1;
    chk(req, bus_rdata, lit);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int rst_at;
    logic saw_rst;
    void'($urandom(32'd2718));
    mclear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_exp(5'h04, 32'h0, "R1 status");
    rd_exp(5'h00, 32'h0, "R1 cfg");
    rd_exp(5'h10, 32'h0, "R1 timer");
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 sys_rst", {31'd0, srst}, 32'd0);

    // R3 configuration readback
    wr(5'h00, 32'hFFFF_9053);
    rd_exp(5'h00, 32'h0000_9053, "R3 cfg");

    // R2 one-shot timer clears enable after reload ticks
    wr(5'h10, 32'h8000_0003);
    rd_exp(5'h10, 32'h8000_0003, "R2 timer armed");
    for (int i = 0; i < 3; i++) cyc(0, 5'h10, 0, 1, "R2 timer");
    rd_exp(5'h10, 32'h0000_0003, "R2 one-shot done");

    // R4 R5 R6 R10 full four-strike sequence
    wr(5'h10, 32'hC000_0001);
    wr(5'h00, 32'h0000_9023);
    wr(5'h08, 32'h1);
    rd_exp(5'h04, 32'h0000_0021, "R4 start");
    cyc(0, 5'h04, 0, 1, "R4");
    rd_exp(5'h04, 32'h0000_0011, "R4 decrement");
    cyc(0, 5'h04, 0, 1, "R5");
    rd_exp(5'h04, 32'h0000_1021, "R5 first expiration");
    chk("R10 irq first strike", {31'd0, irq}, 32'd1);
    rst_at = 0; saw_rst = 0;
    for (int i = 3; i <= 10; i++) begin
      cyc(0, 5'h04, 0, !saw_rst, "R5");
      if (srst && !saw_rst) begin rst_at = i; saw_rst = 1; end
    end
    chk("R6 reset on eighth tick", rst_at, 8);
    rd_exp(5'h04, 32'h0000_0020, "R6 stopped");

    // R7 restart
    wr(5'h08, 32'h1);
    for (int i = 0; i < 3; i++) cyc(0, 5'h04, 0, 1, "R7");
    rd_exp(5'h04, 32'h0000_1011, "R7 before restart");
    wr(5'h08, 32'h1);
    rd_exp(5'h04, 32'h0000_0021, "R7 restarted");
    chk("R7 irq cleared", {31'd0, irq}, 32'd0);

    // R8 disable without key
    wr(5'h08, 32'h2);
    rd_exp(5'h04, 32'h0000_0021, "R8 locked disable");

    // R9 key handling
    wr(5'h0C, 32'h0000_1234);
    wr(5'h08, 32'h2);
    rd_exp(5'h04, 32'h0000_0021, "R9 wrong key");
    wr(5'h0C, 32'h0000_C45A);
    wr(5'h08, 32'h0);
    wr(5'h08, 32'h2);
    rd_exp(5'h04, 32'h0000_0021, "R9 key consumed");
    wr(5'h0C, 32'h0000_C45A);
    wr(5'h08, 32'h2);
    rd_exp(5'h04, 32'h0000_0020, "R9 unlocked disable");

    // R11 no reset enable: wrap and keep running
    wr(5'h00, 32'h0000_1023);
    wr(5'h08, 32'h1);
    saw_rst = 0;
    for (int i = 0; i < 8; i++) begin
      cyc(0, 5'h04, 0, 1, "R11");
      if (srst) saw_rst = 1;
    end
    chk("R11 no pulse", {31'd0, saw_rst}, 32'd0);
    rd_exp(5'h04, 32'h0000_0021, "R11 wrapped");

    // random phase checked against the reference
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic t;
      r = $urandom % 100;
      t = $urandom % 2;
      if (r < 3)
        wr(5'h00, {16'd0, 1'($urandom), 2'd0, 1'($urandom), 8'($urandom % 4 + 1),
                   4'($urandom)}, t);
      else if (r < 8)  wr(5'h08, 32'h1, t);
      else if (r < 11) wr(5'h0C, 32'h0000_C45A, t);
      else if (r < 13) wr(5'h0C, 32'h0000_1234, t);
      else if (r < 17) wr(5'h08, 32'h2, t);
      else if (r < 19)
        wr(5'h10, {1'b1, 1'($urandom % 4 != 0), 22'd0, 8'($urandom % 3 + 1)}, t);
      else begin
        case ($urandom % 4)
          0: cyc(0, 5'h04, 0, t, "R5 status");
          1: cyc(0, 5'h00, 0, t, "R3 cfg");
          2: cyc(0, 5'h10, 0, t, "R2 timer");
          default: cyc(0, 5'h04, 0, t, "R4 status");
        endcase
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule